// File: doc/BRIEF.md
# Frequency-Domain Hann Window and Frame Averager

This block sits right after a streaming FFT. It takes complex bins one at a time. Each frame is bounded by a start marker and an end marker. The block applies a Hann taper in the frequency domain by mixing every bin with its two neighbours. It then forms the squared magnitude of each tapered bin. Finally it averages those magnitudes bin by bin over a programmable number of consecutive frames, keeping the running sums in an internal memory.

Only the frame that completes a group produces output. That frame is emitted as one frame of averaged values, with its own start and end markers. When the averaging count is a power of two, the sum is scaled down by a shift. For any other count the raw sum is emitted, with a flag that says so. Changing the selected transform size restarts the averaging group, so sums from frames of different lengths never mix.

Top module: `spec_win_avg`

## Requirements
- R1: For each component (real and imaginary) the tapered bin is floor((2·X(k) − X(k−1) − X(k+1)) / 4), computed in signed arithmetic. This is the kernel 0.5, −0.25, −0.25.
- R2: The neighbour missing at the first and last bin of a frame is taken as zero. The first output bin of a frame carries `out_sof` and the last carries `out_eof`. The cycle after an input end marker must carry no input beat.
- R3: Each tapered bin is reduced to re² + im² as an unsigned value.
- R4: Within a group the magnitudes are summed bin by bin in memory. The first frame of a group overwrites the stored value instead of adding to it, so no earlier contents leak into a new group.
- R5: Output beats appear only for the frame that completes a group, and the group then restarts. Frames before it produce no output.
- R6: `cfg_avg` is a 5-bit frame count. A value of 0 acts as 1, and values above 16 act as 16.
- R7: When the effective count is 1, 2, 4, 8 or 16, `out_data` is the sum shifted right by log2 of the count and `out_raw` is 0. For any other count, `out_data` is the unscaled sum and `out_raw` is 1.
- R8: `cfg_size` selects the frame length: 0 gives 2^BASE_LOG2 bins, 1 gives twice that, and 2 or 3 give four times that. Any change of `cfg_size` restarts the group, so the next frame begins a new group.
- R9: After reset no output beat is presented until input frames arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| cfg_size | input | 2 | frame length select (R8) |
| cfg_avg | input | 5 | frames per averaging group (R6) |
| in_valid | input | 1 | input bin present |
| in_sof | input | 1 | first bin of a frame |
| in_eof | input | 1 | last bin of a frame |
| in_re | input | DW | real part of the bin, signed |
| in_im | input | DW | imaginary part of the bin, signed |
| out_valid | output | 1 | averaged bin present |
| out_sof | output | 1 | first averaged bin of a frame |
| out_eof | output | 1 | last averaged bin of a frame |
| out_raw | output | 1 | 1 when out_data is an unscaled sum |
| out_data | output | 2*DW+4 | averaged or summed magnitude |

## Verification
The bench builds the block with DW=10 and BASE_LOG2=3. This gives frames of 8, 16 and 32 bins and a 32-word memory. With these values, full sixteen-frame groups, odd counts and a size switch in the middle of a group all fit in a few thousand cycles. Alternating full-scale inputs held over sixteen frames drive the tapered value to its extremes and fill the upper bits of the accumulator.

// File: rtl/spec_win_pkg.sv
package spec_win_pkg;

    // Clamp the configured group size into 1..16.
    function automatic logic [4:0] eff_avg(input logic [4:0] cfg);
        if (cfg == 5'd0)  return 5'd1;
        if (cfg > 5'd16)  return 5'd16;
        return cfg;
    endfunction

    // Scaling shift for power-of-two counts.
    function automatic logic [2:0] avg_shift(input logic [4:0] n);
        case (n)
            5'd2:    return 3'd1;
            5'd4:    return 3'd2;
            5'd8:    return 3'd3;
            5'd16:   return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

    function automatic logic avg_is_pow2(input logic [4:0] n);
        return $onehot(n);
    endfunction

endpackage

// File: rtl/spec_win_hann.sv
module spec_win_hann #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 win_valid,
    output logic                 win_sof,
    output logic                 win_eof,
    output logic signed [DW-1:0] win_re,
    output logic signed [DW-1:0] win_im
);
    typedef struct packed {
        logic signed [DW-1:0] pre;
        logic signed [DW-1:0] pim;
        logic signed [DW-1:0] cre;
        logic signed [DW-1:0] cim;
        logic                 busy;
        logic                 first;
        logic                 flush;
        logic                 ov;
        logic                 osof;
        logic                 oeof;
        logic signed [DW-1:0] ore;
        logic signed [DW-1:0] oim;
    } st_t;

    st_t q, d;

    // (2c - p - n) >>> 2, result always fits DW bits
    function automatic logic signed [DW-1:0] tap3(input logic signed [DW-1:0] p,
                                                  input logic signed [DW-1:0] c,
                                                  input logic signed [DW-1:0] n);
        logic signed [DW+1:0] acc;
        acc = {c[DW-1], c, 1'b0} - {{2{p[DW-1]}}, p} - {{2{n[DW-1]}}, n};
        return acc[DW+1:2];
    endfunction

    always_comb begin
        d      = q;
        d.ov   = 1'b0;
        d.osof = 1'b0;
        d.oeof = 1'b0;
        if (q.flush) begin
            d.ore   = tap3(q.pre, q.cre, '0);
            d.oim   = tap3(q.pim, q.cim, '0);
            d.ov    = 1'b1;
            d.osof  = q.first;
            d.oeof  = 1'b1;
            d.flush = 1'b0;
            d.busy  = 1'b0;
            d.first = 1'b0;
        end else if (in_valid) begin
            if (in_sof) begin
                d.pre   = '0;
                d.pim   = '0;
                d.cre   = in_re;
                d.cim   = in_im;
                d.busy  = 1'b1;
                d.first = 1'b1;
                d.flush = in_eof;
            end else if (q.busy) begin
                d.ore   = tap3(q.pre, q.cre, in_re);
                d.oim   = tap3(q.pim, q.cim, in_im);
                d.ov    = 1'b1;
                d.osof  = q.first;
                d.first = 1'b0;
                d.pre   = q.cre;
                d.pim   = q.cim;
                d.cre   = in_re;
                d.cim   = in_im;
                d.flush = in_eof;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign win_valid = q.ov;
    assign win_sof   = q.osof;
    assign win_eof   = q.oeof;
    assign win_re    = q.ore;
    assign win_im    = q.oim;

    // R2
    no_beat_in_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.flush |-> !in_valid);

    // R2
    last_bin_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_eof && !in_sof && q.busy |=> ##1 (win_valid && win_eof));
endmodule

// File: rtl/spec_win_mag.sv
module spec_win_mag #(
    parameter int DW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 win_valid,
    input  logic                 win_sof,
    input  logic                 win_eof,
    input  logic signed [DW-1:0] win_re,
    input  logic signed [DW-1:0] win_im,
    output logic                 mag_valid,
    output logic                 mag_sof,
    output logic                 mag_eof,
    output logic [2*DW-1:0]      mag
);
    typedef struct packed {
        logic            ov;
        logic            osof;
        logic            oeof;
        logic [2*DW-1:0] omag;
    } st_t;

    st_t q, d;
    logic signed [2*DW-1:0] sq_re, sq_im;

    always_comb begin
        sq_re  = win_re * win_re;
        sq_im  = win_im * win_im;
        d.ov   = win_valid;
        d.osof = win_sof;
        d.oeof = win_eof;
        d.omag = win_valid ? ($unsigned(sq_re) + $unsigned(sq_im)) : q.omag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mag_valid = q.ov;
    assign mag_sof   = q.osof;
    assign mag_eof   = q.oeof;
    assign mag       = q.omag;
endmodule

// File: rtl/spec_win_accum.sv
module spec_win_accum
    import spec_win_pkg::*;
#(
    parameter int DW = 16,
    parameter int IW = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_size,
    input  logic [4:0]        cfg_avg,
    input  logic              mag_valid,
    input  logic              mag_sof,
    input  logic              mag_eof,
    input  logic [2*DW-1:0]   mag,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_eof,
    output logic              out_raw,
    output logic [2*DW+3:0]   out_data
);
    localparam int AW    = 2 * DW + 4;
    localparam int DEPTH = 1 << IW;

    typedef struct packed {
        logic [3:0]    grp;
        logic [IW-1:0] idx;
        logic [1:0]    size;
        logic          ov;
        logic          osof;
        logic          oeof;
        logic          oraw;
        logic [AW-1:0] odata;
    } st_t;

    st_t q, d;
    logic [AW-1:0] mem [DEPTH];
    logic          we;
    logic [IW-1:0] waddr;
    logic [AW-1:0] sum;
    logic [4:0]    n;
    logic [3:0]    grp_eff;
    logic          last;

    always_comb begin
        n       = eff_avg(cfg_avg);
        grp_eff = (cfg_size != q.size) ? 4'd0 : q.grp;
        last    = ({1'b0, grp_eff} >= (n - 5'd1));
        d       = q;
        d.size  = cfg_size;
        d.grp   = grp_eff;
        d.ov    = 1'b0;
        d.osof  = 1'b0;
        d.oeof  = 1'b0;
        we      = 1'b0;
        waddr   = mag_sof ? '0 : q.idx;
        sum     = '0;
        if (mag_valid) begin
            sum   = (grp_eff == 4'd0) ? AW'(mag) : (mem[waddr] + AW'(mag));
            we    = 1'b1;
            d.idx = waddr + 1'b1;
            if (last) begin
                d.ov    = 1'b1;
                d.osof  = mag_sof;
                d.oeof  = mag_eof;
                d.oraw  = !avg_is_pow2(n);
                d.odata = sum >> avg_shift(n);
            end
            if (mag_eof) d.grp = last ? 4'd0 : 4'(grp_eff + 4'd1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= sum;
    end

    assign out_valid = q.ov;
    assign out_sof   = q.osof;
    assign out_eof   = q.oeof;
    assign out_raw   = q.oraw;
    assign out_data  = q.odata;

    // R8
    size_change_clears_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_size != q.size) && !mag_valid |=> q.grp == 4'd0);

    // R5
    eof_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_eof |=> !out_valid);

    // R5
    out_needs_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(mag_valid));
endmodule

// File: rtl/spec_win_avg.sv
module spec_win_avg #(
    parameter int DW        = 16,
    parameter int BASE_LOG2 = 9
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           cfg_size,
    input  logic [4:0]           cfg_avg,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic signed [DW-1:0] in_re,
    input  logic signed [DW-1:0] in_im,
    output logic                 out_valid,
    output logic                 out_sof,
    output logic                 out_eof,
    output logic                 out_raw,
    output logic [2*DW+3:0]      out_data
);
    localparam int IW = BASE_LOG2 + 2;

    logic                 win_valid, win_sof, win_eof;
    logic signed [DW-1:0] win_re, win_im;
    logic                 mag_valid, mag_sof, mag_eof;
    logic [2*DW-1:0]      mag;

    spec_win_hann #(.DW(DW)) u_hann (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_re(in_re), .in_im(in_im),
        .win_valid(win_valid), .win_sof(win_sof), .win_eof(win_eof),
        .win_re(win_re), .win_im(win_im)
    );

    spec_win_mag #(.DW(DW)) u_mag (
        .clk(clk), .rst_n(rst_n),
        .win_valid(win_valid), .win_sof(win_sof), .win_eof(win_eof),
        .win_re(win_re), .win_im(win_im),
        .mag_valid(mag_valid), .mag_sof(mag_sof), .mag_eof(mag_eof), .mag(mag)
    );

    spec_win_accum #(.DW(DW), .IW(IW)) u_acc (
        .clk(clk), .rst_n(rst_n),
        .cfg_size(cfg_size), .cfg_avg(cfg_avg),
        .mag_valid(mag_valid), .mag_sof(mag_sof), .mag_eof(mag_eof), .mag(mag),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .out_raw(out_raw), .out_data(out_data)
    );
endmodule

// File: tb/sim_spec_win_avg.sv
`timescale 1ns/1ps
module sim_spec_win_avg;
    localparam int DW = 10;
    localparam int BL = 3;
    localparam int OW = 2 * DW + 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] cfg_size = 2'd0;
    logic [4:0] cfg_avg = 5'd1;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic signed [DW-1:0] in_re = '0, in_im = '0;
    logic out_valid, out_sof, out_eof, out_raw;
    logic [OW-1:0] out_data;

    always #4 clk = ~clk;

    spec_win_avg #(.DW(DW), .BASE_LOG2(BL)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_avg(cfg_avg),
        .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
        .in_re(in_re), .in_im(in_im),
        .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
        .out_raw(out_raw), .out_data(out_data)
    );

    int checks = 0;
    int failures = 0;
    string tag = "R9";
    int grp = 0;
    int xr [64];
    int xi [64];
    longint acc [64];
    longint exp_val [$];
    bit exp_sof [$];
    bit exp_eof [$];
    bit exp_raw [$];

    function automatic int wnd(input int p, input int c, input int nx);
        return (2 * c - p - nx) >>> 2;
    endfunction

    function automatic int eff_n(input int a);
        if (a == 0) return 1;
        if (a > 16) return 16;
        return a;
    endfunction

    function automatic int shift_of(input int n);
        case (n)
            1: return 0;
            2: return 1;
            4: return 2;
            8: return 3;
            16: return 4;
            default: return -1;
        endcase
    endfunction

    // output monitor: compares every beat with the bench model
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            checks++;
            if (exp_val.size() == 0) begin
                failures++;
                $display("FAIL %s unexpected beat data=%0d exp=none (R5)", tag, out_data);
            end else begin
                longint ev;
                bit es, ee, er;
                ev = exp_val.pop_front();
                es = exp_sof.pop_front();
                ee = exp_eof.pop_front();
                er = exp_raw.pop_front();
                if (longint'(out_data) != ev || out_sof != es || out_eof != ee || out_raw != er) begin
                    failures++;
                    $display("FAIL %s data=%0d exp=%0d sof=%b exp=%b eof=%b exp=%b raw=%b exp=%b",
                             tag, out_data, ev, out_sof, es, out_eof, ee, out_raw, er);
                end
            end
        end
    end

    task automatic set_cfg(input int sz, input int av);
        repeat (6) @(negedge clk);
        if (sz != int'(cfg_size)) grp = 0; // R8 restart
        cfg_size = 2'(sz);
        cfg_avg  = 5'(av);
        repeat (2) @(negedge clk);
    endtask

    task automatic send_frame(input int npts, input bit extreme);
        int n, sh;
        n = eff_n(int'(cfg_avg));
        sh = shift_of(n);
        for (int k = 0; k < npts; k++) begin
            if (extreme) begin
                xr[k] = (k % 2 == 1) ? (2 ** (DW - 1) - 1) : -(2 ** (DW - 1));
                xi[k] = (k % 2 == 0) ? (2 ** (DW - 1) - 1) : -(2 ** (DW - 1));
            end else begin
                xr[k] = int'($urandom_range(0, 2 ** DW - 1)) - 2 ** (DW - 1);
                xi[k] = int'($urandom_range(0, 2 ** DW - 1)) - 2 ** (DW - 1);
            end
        end
        for (int k = 0; k < npts; k++) begin
            int yr, yi;
            longint m;
            yr = wnd(k > 0 ? xr[k-1] : 0, xr[k], k < npts - 1 ? xr[k+1] : 0);
            yi = wnd(k > 0 ? xi[k-1] : 0, xi[k], k < npts - 1 ? xi[k+1] : 0);
            m = longint'(yr) * yr + longint'(yi) * yi;
            acc[k] = (grp == 0) ? m : acc[k] + m;
        end
        if (grp >= n - 1) begin
            for (int k = 0; k < npts; k++) begin
                exp_val.push_back(sh >= 0 ? (acc[k] >> sh) : acc[k]);
                exp_sof.push_back(k == 0);
                exp_eof.push_back(k == npts - 1);
                exp_raw.push_back(sh < 0);
            end
            grp = 0;
        end else begin
            grp++;
        end
        for (int k = 0; k < npts; k++) begin
            if ($urandom_range(0, 3) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_sof = (k == 0);
            in_eof = (k == npts - 1);
            in_re = DW'(xr[k]);
            in_im = DW'(xi[k]);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_sof = 1'b0;
        in_eof = 1'b0;
        @(negedge clk); // R2 idle cycle after end marker
    endtask

    initial begin
        #(8 * 150000);
        checks++;
        failures++;
        $display("FAIL watchdog expired (%s) actual=hung expected=done", tag);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int seed_set;
        seed_set = int'($urandom(32'd9137));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9: nothing presented after reset
        repeat (5) begin
            @(negedge clk);
            checks++;
            if (out_valid !== 1'b0) begin
                failures++;
                $display("FAIL R9 out_valid=%b expected=0", out_valid);
            end
        end

        // R1 R2 R3: single-frame groups, random bins
        tag = "R1 R2 R3";
        set_cfg(0, 1);
        repeat (3) send_frame(8, 1'b0);

        // R4 R7: power-of-two group, scaled output
        tag = "R4 R7";
        set_cfg(1, 4);
        repeat (4) send_frame(16, 1'b0);

        // R5 R7: count of three, raw sums, two groups
        tag = "R5 R7";
        set_cfg(2, 3);
        repeat (6) send_frame(32, 1'b0);

        // R6 R7: count above 16 acts as 16, full-scale alternating bins
        tag = "R6 R7 extreme";
        set_cfg(0, 31);
        repeat (16) send_frame(8, 1'b1);

        // R6: zero count acts as one
        tag = "R6 zero";
        set_cfg(0, 0);
        repeat (2) send_frame(8, 1'b0);

        // R8 R4: size change mid-group discards partial sums
        tag = "R8 R4";
        set_cfg(0, 4);
        repeat (2) send_frame(8, 1'b0);
        set_cfg(1, 4);
        repeat (4) send_frame(16, 1'b0);

        repeat (20) @(negedge clk);
        tag = "R5 drain";
        checks++;
        if (exp_val.size() != 0) begin
            failures++;
            $display("FAIL R5 missing beats actual=%0d expected=0", exp_val.size());
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule